// File: doc/BRIEF.md
# Fail-Safe Output Test-Stop Sequencer

This block runs a forced self-check on a bank of fail-safe digital outputs. Each output has a high-side switch and a low-side switch. A start request first performs a four-step request/acknowledge handshake with a partner channel. The block then drives both switches of every output through a fixed sequence of five switch combinations. After each combination it samples the read-back output levels and up to two diagnostic inputs, and compares them with the values expected for that step.

The first mismatch in a run is packed into a 32-bit fault word that stays latched until it is cleared. The end of the run is marked by a one-cycle completion pulse that carries a fail flag. When no test is running, the switches follow the normal functional commands.

The drivers, the read-back circuits and the link to the partner channel are outside the block and appear only as plain ports. The bank has at most four outputs, because every per-channel field of the fault word is one nibble wide.

Top module: `dout_selftest`

## Requirements
- R1: While `rst` is high, both switch outputs are all zero. After reset the block is idle, with `busy`, `done`, `peerReq` and `faultWord` all zero. While idle, `drvHigh`/`drvLow` equal `funcHigh`/`funcLow` in the same cycle.
- R2: A start request moves the block to step 0. Steps 0 to 3 are handshake steps, and in them `peerReq` is 1 in steps 0 and 2 and 0 in steps 1 and 3. A handshake step advances when `peerAck` equals `peerReq`. Both switches are off in steps 0 to 3 and in step 14.
- R3: Steps 4, 6, 8, 10 and 12 drive (high, low) as (0,0), (1,1), (0,1), (1,0) and (0,0) on every channel. Each odd step from 5 to 13 keeps the previous drive, compares the inputs for one cycle, and then moves to the next step.
- R4: Each drive step lasts `settleCycles`+1 cycles, using the value captured at start. If the captured value is 0, the first check step (step 5) records reason 3, the settle fault.
- R5: The expected read-back for every channel is the logical AND of its two switch states. A mismatch records reason 2.
- R6: The first diagnostic input `diagA` is checked in mode 1 (`modeSel`=0) and in mode 4 (`modeSel`=3). At steps 5, 7, 9, 11 and 13 it is expected to read 0,0,0,1,0 in mode 1 and 1,0,0,1,1 in mode 4, on every channel. A mismatch records reason 4.
- R7: The second diagnostic input `diagB` is checked only in mode 4, where it is expected to read 1,0,1,0,1 at steps 5, 7, 9, 11 and 13. A mismatch records reason 5. In modes 2 and 3 (`modeSel`=1 and 2) neither diagnostic input has any effect.
- R8: `faultWord` bits [3:0] hold the step and bits [7:4] the reason. Bits [11:8] hold the mask of failing channels, bits [15:12] the expected state and bits [19:16] the sampled state, with bit n standing for channel n. Bits [31:20] are always zero. For reasons 1 and 3, bits [19:8] are zero.
- R9: Only the first fault since the last clear is kept. Within one check step the priority is reason 3, then 2, then 4, then 5.
- R10: If a handshake step does not complete within `SYNC_TIMEOUT` cycles, the block records reason 1 with that step number and jumps straight to step 14.
- R11: Step 14 lasts one cycle, and in that cycle `done` is 1 and `fail` shows whether a fault is latched. The fault word then holds until `clearFault` is asserted, which zeroes it at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| startReq | input | 1 | Starts a test run when idle |
| clearFault | input | 1 | Clears the latched fault word |
| modeSel | input | 2 | Diagnostic mode 1..4 encoded as 0..3 |
| settleCycles | input | SETTLE_W | Extra settle cycles per drive step |
| funcHigh | input | NUM_CH | Functional high-side command |
| funcLow | input | NUM_CH | Functional low-side command |
| readback | input | NUM_CH | Read-back output levels |
| diagA | input | NUM_CH | First diagnostic read-back |
| diagB | input | NUM_CH | Second diagnostic read-back |
| peerAck | input | 1 | Partner channel handshake answer |
| drvHigh | output | NUM_CH | High-side switch drive |
| drvLow | output | NUM_CH | Low-side switch drive |
| peerReq | output | 1 | Handshake request to partner |
| busy | output | 1 | Test run in progress |
| stepNum | output | 4 | Current test step |
| done | output | 1 | One-cycle end-of-test pulse |
| fail | output | 1 | Fault latched, valid with done |
| faultWord | output | 32 | Packed first-fault record |

## Verification
The step number is a port, and the switch drive follows from it combinationally. A corrupted step register therefore shows up as a wrong `drvHigh`/`drvLow` pair or a wrong `peerReq` level in the same cycle. A corrupted settle counter shows up as a drive step of the wrong length, which is visible within one settle window. Faults in the compare or packing logic appear in `faultWord` at the failing check step, and are confirmed when `done` rises one to a few dozen cycles later.

// File: rtl/dout_selftest_pkg.sv
package dout_selftest_pkg;

  localparam logic [3:0] RSN_SEQ   = 4'd1;
  localparam logic [3:0] RSN_RB    = 4'd2;
  localparam logic [3:0] RSN_TMR   = 4'd3;
  localparam logic [3:0] RSN_DIAG1 = 4'd4;
  localparam logic [3:0] RSN_DIAG2 = 4'd5;

  localparam logic [3:0] STEP_LAST_SYNC  = 4'd3;
  localparam logic [3:0] STEP_FIRST_DRV  = 4'd4;
  localparam logic [3:0] STEP_LAST_CHECK = 4'd13;
  localparam logic [3:0] STEP_END        = 4'd14;

  typedef struct packed {
    logic arm;
    logic clrTimer;
    logic incTimer;
    logic loadSettle;
    logic decSettle;
    logic checkNow;
    logic syncFault;
  } seq_strobe_t;

  // pattern index 0..4 for steps 4..13 (drive step and its check step share it)
  function automatic logic [2:0] phaseOf(input logic [3:0] step);
    logic [3:0] rel;
    rel = step - STEP_FIRST_DRV;
    return rel[3:1];
  endfunction

  function automatic logic patHigh(input logic [3:0] step);
    logic [2:0] ph;
    if (step < STEP_FIRST_DRV || step > STEP_LAST_CHECK) return 1'b0;
    ph = phaseOf(step);
    return (ph == 3'd1) || (ph == 3'd3);
  endfunction

  function automatic logic patLow(input logic [3:0] step);
    logic [2:0] ph;
    if (step < STEP_FIRST_DRV || step > STEP_LAST_CHECK) return 1'b0;
    ph = phaseOf(step);
    return (ph == 3'd1) || (ph == 3'd2);
  endfunction

endpackage

// File: rtl/dout_selftest_ctrl.sv
module dout_selftest_ctrl
  import dout_selftest_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startReq,
  input  logic              peerAck,
  input  logic              settleZero,
  input  logic              timeoutHit,
  input  logic [NUM_CH-1:0] funcHigh,
  input  logic [NUM_CH-1:0] funcLow,
  output seq_strobe_t       strb,
  output logic              busy,
  output logic [3:0]        step,
  output logic              peerReq,
  output logic [NUM_CH-1:0] drvHigh,
  output logic [NUM_CH-1:0] drvLow,
  output logic              done
);

  logic       busyNext;
  logic [3:0] stepNext;
  logic       ackWanted;

  assign ackWanted = ~step[0];

  always_comb begin
    busyNext = busy;
    stepNext = step;
    strb     = '0;
    if (!busy) begin
      if (startReq) begin
        busyNext      = 1'b1;
        stepNext      = 4'd0;
        strb.arm      = 1'b1;
        strb.clrTimer = 1'b1;
      end
    end else if (step <= STEP_LAST_SYNC) begin
      if (peerAck == ackWanted) begin
        stepNext      = step + 4'd1;
        strb.clrTimer = 1'b1;
        if (step == STEP_LAST_SYNC) strb.loadSettle = 1'b1;
      end else if (timeoutHit) begin
        strb.syncFault = 1'b1;
        stepNext       = STEP_END;
      end else begin
        strb.incTimer = 1'b1;
      end
    end else if (step == STEP_END) begin
      busyNext = 1'b0;
      stepNext = 4'd0;
    end else if (!step[0]) begin
      if (settleZero) stepNext = step + 4'd1;
      else            strb.decSettle = 1'b1;
    end else begin
      strb.checkNow   = 1'b1;
      strb.loadSettle = 1'b1;
      stepNext        = step + 4'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      step <= 4'd0;
    end else begin
      busy <= busyNext;
      step <= stepNext;
    end
  end

  assign peerReq = busy && (step <= STEP_LAST_SYNC) && ackWanted;
  assign done    = busy && (step == STEP_END);

  always_comb begin
    if (rst) begin
      drvHigh = '0;
      drvLow  = '0;
    end else if (busy) begin
      drvHigh = {NUM_CH{patHigh(step)}};
      drvLow  = {NUM_CH{patLow(step)}};
    end else begin
      drvHigh = funcHigh;
      drvLow  = funcLow;
    end
  end

endmodule

// File: rtl/dout_selftest_dp.sv
module dout_selftest_dp
  import dout_selftest_pkg::*;
#(
  parameter int NUM_CH       = 4,
  parameter int SETTLE_W     = 8,
  parameter int SYNC_TIMEOUT = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clearFault,
  input  seq_strobe_t         strb,
  input  logic [3:0]          step,
  input  logic [SETTLE_W-1:0] settleCycles,
  input  logic [1:0]          modeSel,
  input  logic [NUM_CH-1:0]   readback,
  input  logic [NUM_CH-1:0]   diagA,
  input  logic [NUM_CH-1:0]   diagB,
  output logic                settleZero,
  output logic                timeoutHit,
  output logic [31:0]         faultWord,
  output logic                faultValid
);

  localparam int TMR_W = $clog2(SYNC_TIMEOUT + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(SYNC_TIMEOUT - 1);
  localparam logic [1:0] MODE_ONE  = 2'd0;
  localparam logic [1:0] MODE_FOUR = 2'd3;
  // expected diagnostic level per pattern index 0..4 (bit i = index i)
  localparam logic [4:0] DIAG1_M1 = 5'b01000;
  localparam logic [4:0] DIAG1_M4 = 5'b11001;
  localparam logic [4:0] DIAG2_M4 = 5'b10101;

  logic [SETTLE_W-1:0] settleCfg, settleCnt;
  logic [1:0]          modeCfg;
  logic [TMR_W-1:0]    syncTmr;

  always_ff @(posedge clk) begin
    if (rst) begin
      settleCfg <= '0;
      modeCfg   <= '0;
      settleCnt <= '0;
      syncTmr   <= '0;
    end else begin
      if (strb.arm) begin
        settleCfg <= settleCycles;
        modeCfg   <= modeSel;
      end
      if (strb.clrTimer)      syncTmr <= '0;
      else if (strb.incTimer) syncTmr <= syncTmr + 1'b1;
      if (strb.loadSettle)     settleCnt <= settleCfg;
      else if (strb.decSettle) settleCnt <= settleCnt - 1'b1;
    end
  end

  assign settleZero = (settleCnt == '0);
  assign timeoutHit = (syncTmr == TMR_LAST);

  function automatic logic [3:0] toNib(input logic [NUM_CH-1:0] v);
    logic [3:0] n;
    n = '0;
    n[NUM_CH-1:0] = v;
    return n;
  endfunction

  // compare logic
  logic [2:0]        phase;
  logic [NUM_CH-1:0] expRb, expA, expB, rbErr, aErr, bErr;
  logic              chkA, chkB, settleBad;
  logic              candHit;
  logic [3:0]        candRsn;
  logic [NUM_CH-1:0] candV, candW, candX;

  always_comb begin
    phase     = phaseOf(step);
    expRb     = {NUM_CH{patHigh(step) & patLow(step)}};
    expA      = {NUM_CH{(modeCfg == MODE_FOUR) ? DIAG1_M4[phase] : DIAG1_M1[phase]}};
    expB      = {NUM_CH{DIAG2_M4[phase]}};
    chkA      = (modeCfg == MODE_ONE) || (modeCfg == MODE_FOUR);
    chkB      = (modeCfg == MODE_FOUR);
    rbErr     = readback ^ expRb;
    aErr      = diagA ^ expA;
    bErr      = diagB ^ expB;
    settleBad = (settleCfg == '0) || !settleZero;

    candHit = 1'b1;
    candRsn = RSN_TMR;
    candV   = '0;
    candW   = '0;
    candX   = '0;
    if (settleBad) begin
      candRsn = RSN_TMR;
    end else if (|rbErr) begin
      candRsn = RSN_RB;
      candV = readback; candW = expRb; candX = rbErr;
    end else if (chkA && |aErr) begin
      candRsn = RSN_DIAG1;
      candV = diagA; candW = expA; candX = aErr;
    end else if (chkB && |bErr) begin
      candRsn = RSN_DIAG2;
      candV = diagB; candW = expB; candX = bErr;
    end else begin
      candHit = 1'b0;
    end
  end

  // first-fault capture
  always_ff @(posedge clk) begin
    if (rst || clearFault) begin
      faultWord  <= '0;
      faultValid <= 1'b0;
    end else if (!faultValid) begin
      if (strb.syncFault) begin
        faultWord  <= {12'h000, 12'h000, RSN_SEQ, step};
        faultValid <= 1'b1;
      end else if (strb.checkNow && candHit) begin
        faultWord  <= {12'h000, toNib(candV), toNib(candW), toNib(candX), candRsn, step};
        faultValid <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/dout_selftest.sv
module dout_selftest
  import dout_selftest_pkg::*;
#(
  parameter int NUM_CH       = 4,
  parameter int SETTLE_W     = 8,
  parameter int SYNC_TIMEOUT = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                startReq,
  input  logic                clearFault,
  input  logic [1:0]          modeSel,
  input  logic [SETTLE_W-1:0] settleCycles,
  input  logic [NUM_CH-1:0]   funcHigh,
  input  logic [NUM_CH-1:0]   funcLow,
  input  logic [NUM_CH-1:0]   readback,
  input  logic [NUM_CH-1:0]   diagA,
  input  logic [NUM_CH-1:0]   diagB,
  input  logic                peerAck,
  output logic [NUM_CH-1:0]   drvHigh,
  output logic [NUM_CH-1:0]   drvLow,
  output logic                peerReq,
  output logic                busy,
  output logic [3:0]          stepNum,
  output logic                done,
  output logic                fail,
  output logic [31:0]         faultWord
);

  seq_strobe_t strb;
  logic        settleZero, timeoutHit, faultValid;

  dout_selftest_ctrl #(.NUM_CH(NUM_CH)) ctrl (
    .clk(clk), .rst(rst), .startReq(startReq), .peerAck(peerAck),
    .settleZero(settleZero), .timeoutHit(timeoutHit),
    .funcHigh(funcHigh), .funcLow(funcLow),
    .strb(strb), .busy(busy), .step(stepNum), .peerReq(peerReq),
    .drvHigh(drvHigh), .drvLow(drvLow), .done(done)
  );

  dout_selftest_dp #(.NUM_CH(NUM_CH), .SETTLE_W(SETTLE_W), .SYNC_TIMEOUT(SYNC_TIMEOUT)) dp (
    .clk(clk), .rst(rst), .clearFault(clearFault), .strb(strb), .step(stepNum),
    .settleCycles(settleCycles), .modeSel(modeSel),
    .readback(readback), .diagA(diagA), .diagB(diagB),
    .settleZero(settleZero), .timeoutHit(timeoutHit),
    .faultWord(faultWord), .faultValid(faultValid)
  );

  assign fail = done & faultValid;

endmodule

// File: rtl/dout_selftest_chk.sv
module dout_selftest_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              clearFault,
  input logic [NUM_CH-1:0] drvHigh,
  input logic [NUM_CH-1:0] drvLow,
  input logic              peerReq,
  input logic              busy,
  input logic [3:0]        stepNum,
  input logic              done,
  input logic [31:0]       faultWord
);

  always_comb begin
    if (rst) AST_RESET_OFF: assert (drvHigh == '0 && drvLow == '0); // R1
  end

  AST_SYNC_END_OFF: assert property (@(posedge clk) disable iff (rst)
    busy && (stepNum <= 4'd3 || stepNum == 4'd14) |-> drvHigh == '0 && drvLow == '0); // R2

  AST_REQ_PHASE: assert property (@(posedge clk) disable iff (rst)
    busy && stepNum <= 4'd3 |-> peerReq == ~stepNum[0]); // R2

  AST_CHECK_HOLD: assert property (@(posedge clk) disable iff (rst)
    busy && stepNum[0] && stepNum >= 4'd5 |-> $stable(drvHigh) && $stable(drvLow)); // R3

  AST_CHECK_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    busy && stepNum[0] && stepNum >= 4'd5 |=> stepNum == $past(stepNum) + 4'd1); // R3

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    faultWord[31:20] == 12'h000); // R8

  AST_FIRST_KEPT: assert property (@(posedge clk) disable iff (rst)
    faultWord != 32'h0 && !clearFault |=> faultWord == $past(faultWord)); // R9

  AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R11

  AST_CLEAR: assert property (@(posedge clk) disable iff (rst)
    clearFault |=> faultWord == 32'h0); // R11

endmodule

bind dout_selftest dout_selftest_chk #(.NUM_CH(NUM_CH)) chkInst (.*);

// File: tb/dout_selftest_test.sv
module dout_selftest_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        startReq = 1'b0;
  logic        clearFault = 1'b0;
  logic [1:0]  modeSel = 2'd0;
  logic [7:0]  settleCycles = 8'd1;
  logic [3:0]  funcHigh = 4'hA;
  logic [3:0]  funcLow = 4'h5;
  logic [3:0]  readback = '0, diagA = '0, diagB = '0;
  logic        peerAck = 1'b0;
  logic [3:0]  drvHigh, drvLow, stepNum;
  logic        peerReq, busy, done, fail;
  logic [31:0] faultWord;

  int checks = 0, fails = 0;
  int step4Cycles = 0, doneCount = 0;
  bit ackEnable = 1'b1;
  logic [3:0] injStep = '0, injKind = '0, injMask = '0;

  always #2 clk = ~clk;

  dout_selftest uut (
    .clk(clk), .rst(rst), .startReq(startReq), .clearFault(clearFault),
    .modeSel(modeSel), .settleCycles(settleCycles), .funcHigh(funcHigh), .funcLow(funcLow),
    .readback(readback), .diagA(diagA), .diagB(diagB), .peerAck(peerAck),
    .drvHigh(drvHigh), .drvLow(drvLow), .peerReq(peerReq), .busy(busy),
    .stepNum(stepNum), .done(done), .fail(fail), .faultWord(faultWord)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic benchDiagA(input logic [1:0] m, input logic [3:0] s);
    case (m)
      2'd0:    return s == 4'd11;
      2'd3:    return s == 4'd5 || s == 4'd11 || s == 4'd13;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic benchDiagB(input logic [1:0] m, input logic [3:0] s);
    return m == 2'd3 && (s == 4'd5 || s == 4'd9 || s == 4'd13);
  endfunction

  // partner and read-back models, updated away from the active edge
  always @(negedge clk) begin
    automatic bit hit = busy && stepNum[0] && stepNum >= 4'd5 && stepNum <= 4'd13 &&
                        (injStep == 4'hF || injStep == stepNum);
    peerAck  = ackEnable & peerReq;
    readback = (drvHigh & drvLow) ^ ((hit && injKind == 4'd2) ? injMask : 4'h0);
    diagA    = {4{benchDiagA(modeSel, stepNum)}} ^ ((hit && injKind == 4'd4) ? injMask : 4'h0);
    diagB    = {4{benchDiagB(modeSel, stepNum)}} ^ ((hit && injKind == 4'd5) ? injMask : 4'h0);
  end

  // per-step drive monitor
  always @(negedge clk) begin
    if (!rst && busy) begin
      automatic logic eh = 1'b0, el = 1'b0;
      case (stepNum)
        4'd6, 4'd7:  begin eh = 1'b1; el = 1'b1; end
        4'd8, 4'd9:  begin eh = 1'b0; el = 1'b1; end
        4'd10, 4'd11: begin eh = 1'b1; el = 1'b0; end
        default: ;
      endcase
      if (stepNum <= 4'd3 || stepNum == 4'd14)
        check(drvHigh == 4'h0 && drvLow == 4'h0, "R2 switches off", {drvHigh, drvLow}, 32'h0);
      else
        check(drvHigh == {4{eh}} && drvLow == {4{el}}, "R3 drive pattern",
              {20'h0, stepNum, drvHigh, drvLow}, {20'h0, stepNum, {4{eh}}, {4{el}}});
      if (stepNum <= 4'd3)
        check(peerReq == ~stepNum[0], "R2 peerReq phase", {31'h0, peerReq}, {31'h0, ~stepNum[0]});
      if (stepNum == 4'd4) step4Cycles++;
      if (done) doneCount++;
    end
  end

  task automatic runTest(input logic [1:0] m, input logic [7:0] s, input logic [3:0] iStep,
                         input logic [3:0] iKind, input logic [3:0] iMask,
                         input logic [31:0] expW, input bit expF, input int expS4, input string tag);
    bit seen = 1'b0;
    modeSel = m; settleCycles = s; injStep = iStep; injKind = iKind; injMask = iMask;
    @(negedge clk) clearFault = 1'b1;
    @(negedge clk) begin clearFault = 1'b0; startReq = 1'b1; step4Cycles = 0; doneCount = 0; end
    @(negedge clk) startReq = 1'b0;
    for (int c = 0; c < 3000 && !seen; c++) begin
      @(negedge clk);
      if (done) begin
        seen = 1'b1;
        check(fail == expF, "R11 fail flag", {31'h0, fail}, {31'h0, expF});
        check(faultWord == expW, tag, faultWord, expW);
      end
    end
    check(seen, "R11 done seen", {31'h0, seen}, 32'h1);
    repeat (3) @(negedge clk);
    check(doneCount == 1, "R11 done width", doneCount, 1);
    check(faultWord == expW, "R11 fault held", faultWord, expW);
    check(!busy, "R11 back to idle", {31'h0, busy}, 32'h0);
    check(step4Cycles == expS4, "R4 settle length", step4Cycles, expS4);
  endtask

  typedef struct packed {
    logic [1:0]  mode;
    logic [7:0]  settle;
    logic [3:0]  iStep;
    logic [3:0]  iKind;
    logic [3:0]  iMask;
    logic [31:0] expW;
    logic        expF;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{2'd3, 8'd3, 4'd0,  4'd0, 4'h0, 32'h0000_0000, 1'b0}, // R3 R5 R6 R7 clean mode 4
    '{2'd0, 8'd2, 4'd0,  4'd0, 4'h0, 32'h0000_0000, 1'b0}, // R6 clean mode 1
    '{2'd3, 8'd1, 4'd7,  4'd2, 4'h2, 32'h000D_F227, 1'b1}, // R5 R8 read-back miss at step 7
    '{2'd1, 8'd4, 4'd5,  4'd2, 4'h8, 32'h0008_0825, 1'b1}, // R5 read-back miss at step 5
    '{2'd0, 8'd1, 4'd11, 4'd4, 4'h1, 32'h000E_F14B, 1'b1}, // R6 diagA miss mode 1
    '{2'd3, 8'd2, 4'd9,  4'd5, 4'h6, 32'h0009_F659, 1'b1}, // R7 diagB miss mode 4
    '{2'd0, 8'd2, 4'd9,  4'd5, 4'h6, 32'h0000_0000, 1'b0}, // R7 diagB ignored in mode 1
    '{2'd1, 8'd1, 4'd5,  4'd4, 4'hF, 32'h0000_0000, 1'b0}, // R7 diagA ignored in mode 2
    '{2'd3, 8'd0, 4'd0,  4'd0, 4'h0, 32'h0000_0035, 1'b1}, // R4 zero settle
    '{2'd3, 8'd2, 4'hF,  4'd2, 4'h1, 32'h0001_0125, 1'b1}, // R9 first of many kept
    '{2'd3, 8'd1, 4'd13, 4'd4, 4'hF, 32'h0000_FF4D, 1'b1}, // R6 diagA miss mode 4 step 13
    '{2'd2, 8'd0, 4'd5,  4'd2, 4'h1, 32'h0000_0035, 1'b1}  // R9 reason 3 beats reason 2
  };

  initial begin
    int cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 100000) begin
        check(1'b0, "watchdog", cyc, 100000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(drvHigh == 4'h0 && drvLow == 4'h0, "R1 off in reset", {drvHigh, drvLow}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !done && !peerReq && faultWord == 0, "R1 reset state",
          {faultWord[27:0], busy, done, peerReq, 1'b0}, 32'h0);
    check(drvHigh == 4'hA && drvLow == 4'h5, "R1 idle follows", {drvHigh, drvLow}, 32'hA5);
    funcHigh = 4'h3; funcLow = 4'hC;
    @(negedge clk);
    check(drvHigh == 4'h3 && drvLow == 4'hC, "R1 idle follows", {drvHigh, drvLow}, 32'h3C);
    funcHigh = 4'hF; funcLow = 4'hF;

    for (int i = 0; i < NVEC; i++)
      runTest(VECS[i].mode, VECS[i].settle, VECS[i].iStep, VECS[i].iKind, VECS[i].iMask,
              VECS[i].expW, VECS[i].expF, int'(VECS[i].settle) + 1, $sformatf("R8 word vec%0d", i));

    // R10: partner silent -> timeout in step 0, jump to end
    ackEnable = 1'b0;
    runTest(2'd3, 8'd2, 4'd0, 4'd0, 4'h0, 32'h0000_0010, 1'b1, 0, "R10 timeout word");
    ackEnable = 1'b1;

    // R11: clear zeroes the latched word
    @(negedge clk) clearFault = 1'b1;
    @(negedge clk) clearFault = 1'b0;
    check(faultWord == 0, "R11 clear", faultWord, 32'h0);

    // R1: reset mid-run returns to idle with switches off
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
    repeat (8) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(drvHigh == 4'h0 && drvLow == 4'h0 && !busy, "R1 reset mid-run",
          {busy, drvHigh, drvLow}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check(drvHigh == funcHigh && !busy, "R1 idle after reset", {busy, drvHigh}, {1'b0, funcHigh});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule